// File: doc/BRIEF.md
# Open-Drain Address Arbitration Unit

This unit sits on the target side of a two-wire bus that has a push-pull clock line and an open-drain data line. It lets a target ask for service, such as an in-band interrupt or a join, without a dedicated interrupt wire. When a request is pending and the bus is quiet, meaning SCL and SDA are both high, the unit pulls SDA low. The controller answers by starting SCL, which completes a START condition.

During the address phase the unit drives its own address onto the wired-AND data line, most significant bit first. At every rising SCL edge it compares the data line with what it drove. If it released a 1 and sees a 0, another target with a lower address is also driving, and this unit has lost. A loser stops driving for the rest of the frame and keeps its request for a later attempt. A winner reports success after the last address bit and then releases the line for the read/not-write bit, which marks the transfer as a read.

The unit samples SCL and SDA with its own clock and assumes both are already synchronised. The same mechanism serves interrupt requests, join requests using a reserved address, and bus initialisation when addresses are unknown.

Top module: `ibi_arb_unit`

## Requirements
- R1: After reset, `sda_pd_o`, `won_o` and `lost_o` are all low.
- R2: The unit drives SDA only while a request is pending. With a request pending and SCL and SDA both high for two samples, it sets `sda_pd_o` within two clocks and holds it until SCL falls.
- R3: Address bits go out most significant bit first. A 0 bit drives SDA low (`sda_pd_o`=1) and a 1 bit releases it. A driven bit changes only while SCL is low.
- R4: At an SCL rising edge, if the unit is releasing a 1 but SDA reads 0, it pulses `lost_o` high for one clock. It then leaves SDA released for the rest of the frame.
- R5: If all address bits are sampled without a loss, `won_o` pulses high for one clock while SCL is high on the last address bit, and the pending request is cleared.
- R6: After a win, the unit releases SDA during the read/not-write bit, so the bus reads 1 (read).
- R7: A lost request stays pending. After the next STOP (SDA rising while SCL is high) the unit requests again without a new `req_i` pulse.
- R8: If a controller START (SDA falling while SCL is high, not caused by this unit) comes while the unit is idle, the unit does not drive SDA in that frame, even if `req_i` arrives during it. A request pending at the STOP is issued afterwards.
- R9: When several targets contend, the address seen on the bus equals the numerically lowest contending address, and only that target wins.
- R10: `won_o` and `lost_o` are never high together, and each pulses at most once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-clock request pulse |
| own_addr_i | input | ADDR_W | Address used for arbitration |
| scl_i | input | 1 | Bus clock line, synchronised |
| sda_i | input | 1 | Bus data line level, synchronised |
| sda_pd_o | output | 1 | 1 pulls SDA low |
| won_o | output | 1 | One-clock pulse on arbitration win |
| lost_o | output | 1 | One-clock pulse on arbitration loss |

## Verification
A behavioural wired-AND bus, a controller model and a second contending target exercise the main function. Uncontested frames show that each bit is driven in the right order and polarity. Contests with the rival losing at the first, a middle or the last bit separate correct withdrawal from driving on after a loss. When the unit loses at its MSB but still has 0 bits to drive, any failure to withdraw corrupts the rival's address on the bus. Frames with no new request separate retry after STOP from a dropped request. A frame started by the controller, with a request arriving mid-frame, checks that the unit holds off until the STOP.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_LOST,
    ST_DONE,
    ST_BUSY
  } arb_state_e;
endpackage

// File: rtl/arb_bus_mon.sv
module arb_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic quiet_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign quiet_o    = scl_i & scl_q & sda_i & sda_q;
endmodule

// File: rtl/arb_pending.sv
module arb_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/arb_addr_tx.sv
module arb_addr_tx #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ADDR_W - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= TOP_IDX;
    else if (load_i) idx_q <= TOP_IDX;
    else if (step_i) idx_q <= idx_q - 1'b1;
  end

  assign bit_o  = addr_i[idx_q];
  assign last_o = (idx_q == '0);
endmodule

// File: rtl/ibi_arb_unit.sv
module ibi_arb_unit
  import arb_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  output logic              won_o,
  output logic              lost_o
);
  arb_state_e st_q, st_d;
  logic scl_rise, scl_fall, start_det, stop_det, quiet;
  logic pend, bit_val, last_bit;
  logic load, step, win_ev, loss_ev;
  logic won_q, lost_q;

  arb_bus_mon u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .quiet_o   (quiet)
  );

  arb_pending u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (req_i),
    .clr_i (win_ev),
    .pend_o(pend)
  );

  arb_addr_tx #(.ADDR_W(ADDR_W)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .addr_i(own_addr_i),
    .bit_o (bit_val),
    .last_o(last_bit)
  );

  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    step    = 1'b0;
    win_ev  = 1'b0;
    loss_ev = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_det)          st_d = ST_BUSY;   // controller owns this frame
        else if (pend && quiet) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (scl_fall) begin
          st_d = ST_ADDR;
          load = 1'b1;
        end
      end
      ST_ADDR: begin
        if (scl_rise) begin
          if (bit_val && !sda_i) begin
            st_d    = ST_LOST;
            loss_ev = 1'b1;
          end else if (last_bit) begin
            win_ev = 1'b1;
          end
        end else if (scl_fall) begin
          if (last_bit) st_d = ST_DONE;
          else          step = 1'b1;
        end
      end
      default: begin
        if (stop_det) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      won_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      won_q  <= win_ev;
      lost_q <= loss_ev;
    end
  end

  // read/not-write stays released (read) in ST_DONE
  assign sda_pd_o = (st_q == ST_REQ) | ((st_q == ST_ADDR) & ~bit_val);
  assign won_o    = won_q;
  assign lost_o   = lost_q;
endmodule

// File: rtl/arb_unit_chk.sv
module arb_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic sda_pd_o,
  input logic won_o,
  input logic lost_o
);
  AST_WON_LOST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(won_o && lost_o)); // R10
  AST_WON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won_o |=> !won_o); // R5
  AST_WON_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won_o |-> scl_i); // R5
  AST_LOST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |=> !lost_o); // R4
  AST_LOST_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> !sda_pd_o); // R4
  AST_RELEASE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pd_o) |-> !scl_i); // R3
  AST_REQ_ON_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_pd_o) && scl_i) |-> $past(sda_i)); // R2
endmodule

bind ibi_arb_unit arb_unit_chk u_chk (.*);

// File: tb/ibi_arb_unit_tb_top.sv
module ibi_arb_unit_tb_top;
  localparam int H = 4;
  localparam int NV = 10;
  // {own[6:0], new_req, rival_on, rival[6:0]}
  localparam logic [15:0] VEC [NV] = '{
    {7'h5F, 1'b1, 1'b0, 7'h00},
    {7'h77, 1'b1, 1'b1, 7'h5F},
    {7'h77, 1'b0, 1'b0, 7'h00},
    {7'h5F, 1'b1, 1'b1, 7'h77},
    {7'h00, 1'b1, 1'b1, 7'h7F},
    {7'h7F, 1'b1, 1'b1, 7'h7E},
    {7'h7F, 1'b0, 1'b0, 7'h00},
    {7'h2A, 1'b1, 1'b1, 7'h2B},
    {7'h40, 1'b1, 1'b1, 7'h3F},
    {7'h40, 1'b0, 1'b0, 7'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [6:0] own = 7'h00;
  logic scl = 1'b1;
  logic ctrl_pd = 1'b0, rival_pd = 1'b0, rival_on = 1'b0;
  logic [6:0] rival_addr = 7'h00;
  logic sda_pd, won, lost, sda;
  int n_chk = 0, n_fail = 0;
  int won_cnt = 0, lost_cnt = 0, pd_hits = 0, cyc = 0;

  assign sda = ~(sda_pd | ctrl_pd | rival_pd);

  always #10 clk = ~clk;

  ibi_arb_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .own_addr_i(own),
    .scl_i(scl), .sda_i(sda), .sda_pd_o(sda_pd), .won_o(won), .lost_o(lost)
  );

  always @(negedge clk) begin
    if (won)    won_cnt++;
    if (lost)   lost_cnt++;
    if (sda_pd) pd_hits++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    req = 1'b1; @(negedge clk); req = 1'b0;
  endtask

  task automatic clk_bit();
    wait_cyc(H); scl = 1'b1; wait_cyc(H);
  endtask

  task automatic run_frame(input logic cstart, input logic [6:0] caddr,
                           input logic mid_req,
                           output logic [6:0] seen, output logic seen_rnw,
                           output logic got, output int pd_at_stop);
    got = 1'b1;
    seen = '0;
    if (cstart) begin
      ctrl_pd = 1'b1; @(negedge clk);
    end else begin
      for (int t = 0; t < 40 && sda; t++) @(negedge clk);
      if (sda) got = 1'b0;
      if (rival_on) rival_pd = 1'b1;
    end
    wait_cyc(H);
    scl = 1'b0;
    for (int i = 6; i >= 0; i--) begin
      rival_pd = rival_on & ~rival_addr[i];
      ctrl_pd  = cstart & ~caddr[i];
      if (mid_req && i == 3) pulse_req();
      clk_bit();
      seen[i] = sda;
      if (rival_on && rival_addr[i] && !sda) rival_on = 1'b0;
      scl = 1'b0;
    end
    rival_pd = 1'b0;
    ctrl_pd  = cstart;
    clk_bit();
    seen_rnw = sda;
    scl = 1'b0;
    ctrl_pd = 1'b0;
    clk_bit();
    scl = 1'b0;
    ctrl_pd = 1'b1;
    wait_cyc(H);
    pd_at_stop = pd_hits;
    scl = 1'b1;
    wait_cyc(H);
    ctrl_pd = 1'b0;
    rival_on = 1'b0;
    wait_cyc(H);
  endtask

  initial begin
    logic [6:0] seen;
    logic rnw, got;
    int pd0, pds;
    wait_cyc(2);
    // R1: reset state
    chk(sda_pd == 1'b0, "R1 sda_pd", sda_pd, 0);
    chk(won == 1'b0, "R1 won", won, 0);
    chk(lost == 1'b0, "R1 lost", lost, 0);
    rst_n = 1'b1;
    wait_cyc(20);
    // R2: no drive without request
    chk(pd_hits == 0, "R2 idle no drive", pd_hits, 0);
    own = 7'h33;
    pulse_req();
    wait_cyc(2);
    chk(sda_pd == 1'b1, "R2 request pulls", sda_pd, 1);
    wait_cyc(10);
    chk(sda_pd == 1'b1, "R2 held while SCL high", sda_pd, 1);
    won_cnt = 0; lost_cnt = 0;
    run_frame(1'b0, 7'h00, 1'b0, seen, rnw, got, pds);
    chk(seen == 7'h33, "R3 address on bus", seen, 7'h33);
    chk(won_cnt == 1, "R5 single win", won_cnt, 1);

    for (int v = 0; v < NV; v++) begin
      logic [6:0] o, r, exp_addr;
      logic nr, ro, exp_win;
      {o, nr, ro, r} = VEC[v];
      own = o;
      exp_win  = !ro || (o < r);
      exp_addr = (ro && r < o) ? r : o;
      won_cnt = 0; lost_cnt = 0;
      if (nr) pulse_req();
      rival_addr = r;
      rival_on   = ro;
      run_frame(1'b0, 7'h00, 1'b0, seen, rnw, got, pds);
      chk(got == 1'b1, $sformatf("R7 row%0d request issued", v), got, 1);
      chk(seen == exp_addr, $sformatf("R9 row%0d bus address", v), seen, exp_addr);
      chk(won_cnt == int'(exp_win), $sformatf("R5 row%0d won", v), won_cnt, exp_win);
      chk(lost_cnt == int'(!exp_win), $sformatf("R4 row%0d lost", v), lost_cnt, !exp_win);
      chk(!(won_cnt > 0 && lost_cnt > 0), $sformatf("R10 row%0d exclusive", v), won_cnt, 0);
      if (exp_win) chk(rnw == 1'b1, $sformatf("R6 row%0d rnw read", v), rnw, 1);
    end

    // R8: controller frame, request arrives mid-frame
    wait_cyc(8);
    chk(sda_pd == 1'b0, "R8 idle before frame", sda_pd, 0);
    own = 7'h11;
    won_cnt = 0; lost_cnt = 0;
    pd0 = pd_hits;
    run_frame(1'b1, 7'h50, 1'b1, seen, rnw, got, pds);
    chk(pds == pd0, "R8 silent in controller frame", pds - pd0, 0);
    chk(seen == 7'h50, "R8 controller address", seen, 7'h50);
    chk(won_cnt + lost_cnt == 0, "R8 no result", won_cnt + lost_cnt, 0);
    chk(sda_pd == 1'b1, "R8 request after STOP", sda_pd, 1);
    run_frame(1'b0, 7'h00, 1'b0, seen, rnw, got, pds);
    chk(seen == 7'h11 && won_cnt == 1, "R8 deferred win", seen, 7'h11);
    wait_cyc(10);
    chk(sda_pd == 1'b0, "R5 pending cleared", sda_pd, 0);
    summary();
  end
endmodule